// File: doc/BRIEF.md
# Pixel Transparency Write Filter

This block is a single pipeline stage between a raster-operation unit and frame-buffer memory. Each transfer carries a word of several packed pixels: the source pixel, the destination pixel already read from memory, and the raster-op result. For each pixel lane the block decides whether the result is written back or suppressed. Lanes that are suppressed let an object be drawn without its bounding rectangle reaching the display.

Four tests are available, chosen by a 2-bit mode register. The first writes everything. The second suppresses a lane whose result is zero. The third suppresses a lane whose source pixel matches a programmable key color. The fourth suppresses a lane whose destination pixel matches that key. The block passes the result word through unchanged and gives one write-enable bit per lane. It keeps a wrapping count of suppressed lanes. Input and output use valid/ready handshakes, and there is one cycle of latency.

The output stage is a two-state machine. ST_EMPTY moves to ST_FULL when a word is accepted. ST_FULL moves back to ST_EMPTY when the held word is taken and no new word arrives. ST_FULL stays in ST_FULL, reloading, when the held word is taken and a new word is accepted in the same cycle. ST_FULL holds when the output is stalled.

Top module: `pixel_xparent_filter`

## Requirements
- R1: After reset, out_valid is 0, drop_count is 0, the mode is 2'b00 and the key is 0.
- R2: With mode 2'b00, every lane of an accepted word has its out_we bit set to 1.
- R3: With mode 2'b01, out_we bit i is 0 exactly when result lane i (bits i*PIX_W +: PIX_W) equals zero.
- R4: With mode 2'b10, out_we bit i is 0 exactly when source lane i equals the key.
- R5: With mode 2'b11, out_we bit i is 0 exactly when destination lane i equals the key.
- R6: out_data equals the accepted in_res word bit for bit, whatever the write-enable mask.
- R7: A word accepted at a clock edge (in_valid and in_ready both high) is presented with out_valid high right after that edge.
- R8: While out_valid is high and out_ready is low, in_ready is low, and out_data and out_we stay unchanged.
- R9: A configuration write (cfg_we high) at the same edge as an accepted word does not affect that word. It applies from the next accepted word.
- R10: drop_count rises by the number of suppressed lanes of each accepted word, and wraps modulo 2^CNT_W. Without an accepted word it does not change.
- R11: A comparison uses the full pixel width. A lane that differs from the key or from zero only in its top bit is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads cfg_mode and cfg_key |
| cfg_mode | input | 2 | Transparency mode: 00 none, 01 result zero, 10 source equals key, 11 destination equals key |
| cfg_key | input | PIX_W | Key color, compared on every lane |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Stage can accept a word |
| in_src | input | LANES*PIX_W | Packed source pixels, lane i at bits i*PIX_W +: PIX_W |
| in_dst | input | LANES*PIX_W | Packed destination pixels |
| in_res | input | LANES*PIX_W | Packed raster-op results |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Memory side takes the word |
| out_data | output | LANES*PIX_W | Result word to write |
| out_we | output | LANES | Per-lane write enable |
| drop_count | output | CNT_W | Wrapping count of suppressed lanes |

## Verification
The hardest case to reach is a stalled stage where a new word waits at the input, the configuration changes and the stall then releases in the same cycle that the next word is taken. The held word must keep its old mask, and the waiting word must get the mask that belongs to the configuration in force when it is accepted. The directed tests get there by holding out_ready low and presenting a second word. They check that in_ready stays low and the output stays frozen. They then release the stall and check that the word is handed over in one cycle. A separate test sets the configuration write and a pixel word at the same edge. A bench instance with a narrow counter lets the wrap of the suppressed-lane count be reached in a few dozen words.

// File: rtl/pxf_pkg.sv
package pxf_pkg;

    typedef enum logic [1:0] {
        XM_NONE     = 2'b00,
        XM_RES_ZERO = 2'b01,
        XM_SRC_KEY  = 2'b10,
        XM_DST_KEY  = 2'b11
    } xmode_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_st_t;

endpackage

// File: rtl/pxf_cfg_regs.sv
module pxf_cfg_regs
    import pxf_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic [PIX_W-1:0] cfg_key,
    output xmode_t           mode_q,
    output logic [PIX_W-1:0] key_q
);

    // Config is registered: a pixel accepted at the write edge still sees the old values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= XM_NONE;
            key_q  <= '0;
        end else if (cfg_we) begin
            mode_q <= xmode_t'(cfg_mode);
            key_q  <= cfg_key;
        end
    end

endmodule

// File: rtl/pxf_lane_test.sv
module pxf_lane_test
    import pxf_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  xmode_t           mode,
    input  logic [PIX_W-1:0] key,
    input  logic [PIX_W-1:0] src_px,
    input  logic [PIX_W-1:0] dst_px,
    input  logic [PIX_W-1:0] res_px,
    output logic             keep
);

    always_comb begin
        unique case (mode)
            XM_NONE:     keep = 1'b1;
            XM_RES_ZERO: keep = (res_px != '0);
            XM_SRC_KEY:  keep = (src_px != key);
            XM_DST_KEY:  keep = (dst_px != key);
            default:     keep = 1'b1;
        endcase
    end

endmodule

// File: rtl/pxf_out_stage.sv
module pxf_out_stage
    import pxf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic [LANES-1:0]  in_keep,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [LANES-1:0]  out_we,
    output logic              accept
);

    stage_st_t state_q, state_d;
    logic [WORD_W-1:0] data_q;
    logic [LANES-1:0]  we_q;

    assign accept = in_valid && in_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // Payload holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            we_q   <= '0;
        end else if (accept) begin
            data_q <= in_data;
            we_q   <= in_keep;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            ST_FULL: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
        out_data = data_q;
        out_we   = we_q;
    end

endmodule

// File: rtl/pxf_drop_counter.sv
module pxf_drop_counter #(
    parameter int LANES = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [LANES-1:0] keep,
    output logic [CNT_W-1:0] count
);

    localparam int DROP_W = $clog2(LANES + 1);

    logic [DROP_W-1:0] drops;

    always_comb begin
        drops = '0;
        for (int i = 0; i < LANES; i++) begin
            drops = drops + DROP_W'(!keep[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (accept) begin
            count <= count + CNT_W'(drops);
        end
    end

endmodule

// File: rtl/pixel_xparent_filter.sv
module pixel_xparent_filter
    import pxf_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int LANES = 4,
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_mode,
    input  logic [PIX_W-1:0]       cfg_key,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LANES*PIX_W-1:0] in_src,
    input  logic [LANES*PIX_W-1:0] in_dst,
    input  logic [LANES*PIX_W-1:0] in_res,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [LANES*PIX_W-1:0] out_data,
    output logic [LANES-1:0]       out_we,
    output logic [CNT_W-1:0]       drop_count
);

    localparam int WORD_W = LANES * PIX_W;

    xmode_t           mode_q;
    logic [PIX_W-1:0] key_q;
    logic [LANES-1:0] lane_keep;
    logic             accept;

    pxf_cfg_regs #(.PIX_W(PIX_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_mode (cfg_mode),
        .cfg_key  (cfg_key),
        .mode_q   (mode_q),
        .key_q    (key_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pxf_lane_test #(.PIX_W(PIX_W)) u_test (
            .mode   (mode_q),
            .key    (key_q),
            .src_px (in_src[g*PIX_W +: PIX_W]),
            .dst_px (in_dst[g*PIX_W +: PIX_W]),
            .res_px (in_res[g*PIX_W +: PIX_W]),
            .keep   (lane_keep[g])
        );
    end

    pxf_out_stage #(.LANES(LANES), .WORD_W(WORD_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_res),
        .in_keep   (lane_keep),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_we    (out_we),
        .accept    (accept)
    );

    pxf_drop_counter #(.LANES(LANES), .CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .keep   (lane_keep),
        .count  (drop_count)
    );

endmodule

// File: rtl/pxf_checker.sv
module pxf_checker #(
    parameter int PIX_W = 8,
    parameter int LANES = 4,
    parameter int CNT_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic [LANES*PIX_W-1:0] in_res,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [LANES*PIX_W-1:0] out_data,
    input logic [LANES-1:0]       out_we,
    input logic [CNT_W-1:0]       drop_count,
    input logic [1:0]             mode_q
);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && drop_count == '0));

    a_r2_bypass_all: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && mode_q == 2'b00) |=> (&out_we));

    a_r6_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_data == $past(in_res)));

    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r8_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_we)));

    a_r10_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(drop_count));

endmodule

bind pixel_xparent_filter pxf_checker #(
    .PIX_W(PIX_W), .LANES(LANES), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_res     (in_res),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_we     (out_we),
    .drop_count (drop_count),
    .mode_q     (mode_q)
);

// File: tb/test_pixel_xparent_filter.sv
`timescale 1ns/1ps
module test_pixel_xparent_filter;

    localparam int PW = 8;
    localparam int NL = 4;
    localparam int CW = 6;
    localparam int WW = PW * NL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic [PW-1:0] cfg_key = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [WW-1:0] in_src = '0, in_dst = '0, in_res = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [WW-1:0] out_data;
    logic [NL-1:0] out_we;
    logic [CW-1:0] drop_count;

    int checks = 0;
    int failures = 0;
    logic [1:0]    m_mode = 2'b00;
    logic [PW-1:0] m_key = '0;
    int            m_cnt = 0;

    always #2.5 clk = ~clk;

    pixel_xparent_filter #(.PIX_W(PW), .LANES(NL), .CNT_W(CW)) i_pixel_xparent_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_key(cfg_key),
        .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src), .in_dst(in_dst),
        .in_res(in_res), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_we(out_we), .drop_count(drop_count)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NL-1:0] exp_keep(input logic [1:0] m, input logic [PW-1:0] k,
                                               input logic [WW-1:0] s, input logic [WW-1:0] d,
                                               input logic [WW-1:0] r);
        logic [NL-1:0] e;
        for (int i = 0; i < NL; i++) begin
            case (m)
                2'b00: e[i] = 1'b1;
                2'b01: e[i] = (r[i*PW +: PW] != 0);
                2'b10: e[i] = (s[i*PW +: PW] != k);
                default: e[i] = (d[i*PW +: PW] != k);
            endcase
        end
        return e;
    endfunction

    function automatic int zeros(input logic [NL-1:0] v);
        int n = 0;
        for (int i = 0; i < NL; i++) if (!v[i]) n++;
        return n;
    endfunction

    task automatic set_cfg(input logic [1:0] m, input logic [PW-1:0] k);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m; cfg_key = k;
        @(negedge clk);
        cfg_we = 1'b0;
        m_mode = m; m_key = k;
    endtask

    // Sends one word with out_ready high and checks data, mask and count one cycle later.
    task automatic send_word(input logic [WW-1:0] s, input logic [WW-1:0] d,
                             input logic [WW-1:0] r, input string req);
        logic [NL-1:0] e;
        e = exp_keep(m_mode, m_key, s, d, r);
        @(negedge clk);
        in_valid = 1'b1; in_src = s; in_dst = d; in_res = r;
        @(posedge clk);
        #1;
        m_cnt = (m_cnt + zeros(e)) % (1 << CW);
        chk(out_valid == 1'b1, {req, " valid"}, 64'(out_valid), 64'd1);
        chk(out_we == e, {req, " mask"}, 64'(out_we), 64'(e));
        chk(out_data == r, {req, " R6 data"}, 64'(out_data), 64'(r));
        chk(drop_count == CW'(m_cnt), {req, " R10 count"}, 64'(drop_count), 64'(m_cnt));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        chk(drop_count == '0, "R1 count", 64'(drop_count), 64'd0);
        send_word(32'h00000000, 32'h0, 32'h00000000, "R1 default mode none");
    endtask

    task automatic t_modes;
        set_cfg(2'b00, 8'h00);
        send_word(32'h0, 32'h0, 32'h00120000, "R2 bypass");
        set_cfg(2'b01, 8'h00);
        send_word(32'h0, 32'h0, 32'h00120034, "R3 res zero");
        send_word(32'h0, 32'h0, 32'h01010101, "R3 none zero");
        set_cfg(2'b10, 8'h5A);
        send_word(32'h5A005A11, 32'h5A5A5A5A, 32'hAABBCCDD, "R4 src key");
        set_cfg(2'b11, 8'hC3);
        send_word(32'hC3C3C3C3, 32'hC30000C3, 32'h11223344, "R5 dst key");
    endtask

    task automatic t_width;
        set_cfg(2'b10, 8'h5A);
        send_word(32'hDA5ADA5A, 32'h0, 32'h01020304, "R11 src msb");
        set_cfg(2'b01, 8'h00);
        send_word(32'h0, 32'h0, 32'h80008000, "R11 res msb");
    endtask

    task automatic t_cfg_same_edge;
        set_cfg(2'b00, 8'h00);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = 2'b10; cfg_key = 8'h77;
        in_valid = 1'b1; in_src = 32'h77777777; in_dst = '0; in_res = 32'hFFFFFFFF;
        @(posedge clk);
        #1;
        chk(out_we == 4'hF, "R9 old cfg used", 64'(out_we), 64'hF);
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        m_mode = 2'b10; m_key = 8'h77;
        send_word(32'h77777777, 32'h0, 32'hFFFFFFFF, "R9 new cfg next word");
    endtask

    task automatic t_backpressure;
        logic [NL-1:0] ea, eb;
        set_cfg(2'b01, 8'h00);
        ea = exp_keep(m_mode, m_key, '0, '0, 32'h00AA0000);
        eb = exp_keep(m_mode, m_key, '0, '0, 32'h000000BB);
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_res = 32'h00AA0000;
        @(posedge clk);
        #1;
        chk(out_data == 32'h00AA0000, "R7 word A shown", 64'(out_data), 64'h00AA0000);
        @(negedge clk);
        in_res = 32'h000000BB;
        chk(in_ready == 1'b0, "R8 in_ready low", 64'(in_ready), 64'd0);
        @(posedge clk);
        #1;
        chk(out_data == 32'h00AA0000 && out_we == ea, "R8 held data",
            64'(out_data), 64'h00AA0000);
        set_cfg(2'b00, 8'h00);
        #1;
        chk(out_we == ea, "R8 held mask after cfg", 64'(out_we), 64'(ea));
        @(negedge clk);
        out_ready = 1'b1;
        eb = exp_keep(m_mode, m_key, '0, '0, 32'h000000BB);
        #0.1;
        chk(in_ready == 1'b1, "R8 ready on release", 64'(in_ready), 64'd1);
        @(posedge clk);
        #1;
        chk(out_data == 32'h000000BB && out_valid, "R7 word B after release",
            64'(out_data), 64'h000000BB);
        chk(out_we == eb, "R9 word B uses cfg at accept", 64'(out_we), 64'(eb));
        m_cnt = (m_cnt + zeros(ea) + zeros(eb)) % (1 << CW);
        chk(drop_count == CW'(m_cnt), "R10 count after stall", 64'(drop_count), 64'(m_cnt));
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        chk(out_valid == 1'b0, "R7 drains to empty", 64'(out_valid), 64'd0);
        chk(drop_count == CW'(m_cnt), "R10 idle count steady", 64'(drop_count), 64'(m_cnt));
    endtask

    task automatic t_wrap;
        set_cfg(2'b01, 8'h00);
        for (int i = 0; i < 17; i++) begin
            send_word('0, '0, '0, "R10 wrap");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        t_reset();
        t_modes();
        t_width();
        t_cfg_same_edge();
        t_backpressure();
        t_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule